// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides a fast input clock, typically the oscillator output of a frequency synthesizer loop, by a programmable modulus and emits one pulse per completed division. An internal prescaler counts either 9 or 8 input clocks per period. A main counter tallies prescaler periods. A swallow counter decides how many of those periods use the longer count of 9. Taken together, a division spans 8·M + A input clocks.

An 11-bit control word supplies both counts. The upper eight bits give M and the lower three give A. A realisable word needs M at least 1 and A no larger than M. Because of that rule, several moduli below 56 cannot be reached, while every value from 56 to 2047 can. A combinational validity flag reports whether the current word is usable. While the word is unusable, the counters are held cleared and no pulses appear. A new word takes effect only at a division boundary, so a division that is already running finishes with the old modulus.

Top module: `fbdiv_top`

## Requirements
- R1: While the control word is valid and reset is low, successive output pulses are exactly 8·M + A input clocks apart.
- R2: The control word splits into M = ctrlWord[10:3] and A = ctrlWord[2:0]; for example, word 0x011 (M=2, A=1) gives a modulus of 17.
- R3: With A = 0 the prescaler stays at its count of 8 for the whole division, so the modulus is 8·M.
- R4: cfgValid is combinational on ctrlWord and is high exactly when M ≠ 0 and A ≤ M.
- R5: While cfgValid is low, no output pulse is produced and the counters stay cleared, including when the word turns invalid in the middle of a division.
- R6: divPulse is high for exactly one input clock per division.
- R7: A control word change made in the middle of a division does not alter that division; the new modulus governs from the next division on.
- R8: Reset is synchronous and active high. During reset divPulse is low, and the first pulse after reset is released appears on the (8·M + A)-th rising edge.
- R9: When the word turns valid after an invalid period, the first pulse appears on the (8·M + A)-th rising edge after the change.
- R10: Every modulus from 56 to 2047, written as M = modulus/8 and A = modulus mod 8, is realisable and gives that exact pulse spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| ctrlWord | input | 11 | Modulus control word: M in [10:3], A in [2:0] |
| divPulse | output | 1 | One-clock pulse at the end of every division |
| cfgValid | output | 1 | High when ctrlWord describes a realisable modulus |

## Verification
The assertions assume that ctrlWord and rst change only between rising clock edges and that reset is held for at least one edge before any check matters. Under those conditions the prescaler phase is bounded, the swallow count never passes the loaded A, the stored word stays fixed inside a division, and an invalid word silences the output. The stimulus drives every input on the falling edge and asserts reset at time zero, so it stays within those conditions. Invalid words are applied only while the block is deliberately idled.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  // default geometry of the divider
  localparam int PRE_N_DEF  = 8;
  localparam int MAIN_W_DEF = 8;
  localparam int SWAL_W_DEF = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic hold;         // clear counters, no counting
    logic preEnd;       // last clock of the current prescaler period
    logic mainEnd;      // last clock of the whole division
    logic swallowStep;  // current prescaler period is a long (N+1) one
    logic loadCfg;      // capture the control word this edge
  } strobe_t;
endpackage

// File: rtl/fbdiv_control.sv
module fbdiv_control
  import fbdiv_pkg::*;
#(
  parameter int PRE_N  = PRE_N_DEF,
  parameter int MAIN_W = MAIN_W_DEF,
  parameter int SWAL_W = SWAL_W_DEF,
  localparam int PRE_W  = $clog2(PRE_N + 1),
  localparam int CTRL_W = MAIN_W + SWAL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic [PRE_W-1:0]  preCnt,
  input  logic [MAIN_W-1:0] mainCnt,
  input  logic [SWAL_W-1:0] swCnt,
  input  logic [MAIN_W-1:0] effM,
  input  logic [SWAL_W-1:0] effA,
  input  logic              idle,
  output strobe_t           st,
  output logic              cfgValid
);
  logic [MAIN_W-1:0] wordM;
  logic [SWAL_W-1:0] wordA;
  logic              longPeriod;
  logic [PRE_W-1:0]  preLast;
  logic              preEndRaw;
  logic              hold;

  assign wordM = ctrlWord[CTRL_W-1:SWAL_W];
  assign wordA = ctrlWord[SWAL_W-1:0];

  // realisable only if M is nonzero and A does not exceed M
  assign cfgValid = (wordM != '0) && (MAIN_W'(wordA) <= wordM);
  assign hold     = rst || !cfgValid;

  // long periods continue until A of them have been spent
  assign longPeriod = swCnt < effA;
  assign preLast    = longPeriod ? PRE_W'(PRE_N) : PRE_W'(PRE_N - 1);
  assign preEndRaw  = (preCnt == preLast);

  always_comb begin
    st.hold        = hold;
    st.swallowStep = !hold && longPeriod;
    st.preEnd      = !hold && preEndRaw;
    st.mainEnd     = !hold && preEndRaw && (mainCnt == effM - MAIN_W'(1));
    st.loadCfg     = !hold && (idle || st.mainEnd);
  end

  // R7
  cfg_load_point_chk: assert property (@(posedge clk) disable iff (rst)
    st.loadCfg |-> (idle || st.preEnd));

  // R1
  swallow_bound_chk: assert property (@(posedge clk) disable iff (hold)
    !idle |-> (swCnt <= effA));
endmodule

// File: rtl/fbdiv_datapath.sv
module fbdiv_datapath
  import fbdiv_pkg::*;
#(
  parameter int PRE_N  = PRE_N_DEF,
  parameter int MAIN_W = MAIN_W_DEF,
  parameter int SWAL_W = SWAL_W_DEF,
  localparam int PRE_W  = $clog2(PRE_N + 1),
  localparam int CTRL_W = MAIN_W + SWAL_W
) (
  input  logic              clk,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  strobe_t           st,
  output logic [PRE_W-1:0]  preCnt,
  output logic [MAIN_W-1:0] mainCnt,
  output logic [SWAL_W-1:0] swCnt,
  output logic [MAIN_W-1:0] effM,
  output logic [SWAL_W-1:0] effA,
  output logic              idle,
  output logic              divPulse
);
  logic [MAIN_W-1:0] activeM;
  logic [SWAL_W-1:0] activeA;

  // in the first counting clock after a hold the live word is used directly
  assign effM = idle ? ctrlWord[CTRL_W-1:SWAL_W] : activeM;
  assign effA = idle ? ctrlWord[SWAL_W-1:0]      : activeA;

  always_ff @(posedge clk) begin
    if (st.hold) begin
      preCnt   <= '0;
      mainCnt  <= '0;
      swCnt    <= '0;
      idle     <= 1'b1;
      divPulse <= 1'b0;
      activeM  <= '0;
      activeA  <= '0;
    end else begin
      idle     <= 1'b0;
      divPulse <= st.mainEnd;
      if (st.loadCfg) begin
        activeM <= ctrlWord[CTRL_W-1:SWAL_W];
        activeA <= ctrlWord[SWAL_W-1:0];
      end
      if (st.preEnd) begin
        preCnt <= '0;
        if (st.mainEnd) begin
          mainCnt <= '0;
          swCnt   <= '0;
        end else begin
          mainCnt <= mainCnt + MAIN_W'(1);
          if (st.swallowStep) swCnt <= swCnt + SWAL_W'(1);
        end
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  // R1
  pre_range_chk: assert property (@(posedge clk) disable iff (st.hold)
    preCnt <= PRE_W'(PRE_N));

  // R7
  word_steady_chk: assert property (@(posedge clk) disable iff (st.hold)
    (!idle && !st.mainEnd) |=> ($stable(activeM) && $stable(activeA)));

  // R1
  restart_phase_chk: assert property (@(posedge clk) disable iff (st.hold)
    st.mainEnd |=> (preCnt == '0 && mainCnt == '0 && swCnt == '0));
endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
  import fbdiv_pkg::*;
#(
  parameter int PRE_N  = PRE_N_DEF,
  parameter int MAIN_W = MAIN_W_DEF,
  parameter int SWAL_W = SWAL_W_DEF,
  localparam int PRE_W  = $clog2(PRE_N + 1),
  localparam int CTRL_W = MAIN_W + SWAL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrlWord,
  output logic              divPulse,
  output logic              cfgValid
);
  strobe_t           st;
  logic [PRE_W-1:0]  preCnt;
  logic [MAIN_W-1:0] mainCnt;
  logic [SWAL_W-1:0] swCnt;
  logic [MAIN_W-1:0] effM;
  logic [SWAL_W-1:0] effA;
  logic              idle;

  fbdiv_control #(.PRE_N(PRE_N), .MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) uCtrl (
    .clk(clk), .rst(rst), .ctrlWord(ctrlWord),
    .preCnt(preCnt), .mainCnt(mainCnt), .swCnt(swCnt),
    .effM(effM), .effA(effA), .idle(idle),
    .st(st), .cfgValid(cfgValid)
  );

  fbdiv_datapath #(.PRE_N(PRE_N), .MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) uPath (
    .clk(clk), .ctrlWord(ctrlWord), .st(st),
    .preCnt(preCnt), .mainCnt(mainCnt), .swCnt(swCnt),
    .effM(effM), .effA(effA), .idle(idle), .divPulse(divPulse)
  );

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    divPulse |=> !divPulse);

  // R5
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cfgValid |=> !divPulse);

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !divPulse);
endmodule

// File: tb/sim_fbdiv_top.sv
`timescale 1ns/1ps
module sim_fbdiv_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] ctrlWord = 11'd8;
  logic        divPulse;
  logic        cfgValid;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fbdiv_top u0 (.clk(clk), .rst(rst), .ctrlWord(ctrlWord),
                .divPulse(divPulse), .cfgValid(cfgValid));

  function automatic int expMod(logic [10:0] w);
    return int'(w[10:3]) * 8 + int'(w[2:0]);
  endfunction

  function automatic bit expValid(logic [10:0] w);
    return (w[10:3] != 8'd0) && ({5'd0, w[2:0]} <= w[10:3]);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // count rising edges until divPulse is seen high at a falling edge
  task automatic waitPulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!divPulse && n < 5000);
  endtask

  task automatic resetRun(logic [10:0] w, string req);
    int n;
    @(negedge clk);
    rst = 1'b1;
    ctrlWord = w;
    @(negedge clk);
    check(divPulse == 1'b0, "R8 pulse low in reset", int'(divPulse), 0);
    rst = 1'b0;
    waitPulse(n);
    check(n == expMod(w), "R8 first pulse after reset", n, expMod(w));
    @(negedge clk);
    check(divPulse == 1'b0, "R6 pulse one clock wide", int'(divPulse), 0);
    waitPulse(n);
    check(n + 1 == expMod(w), req, n + 1, expMod(w));
  endtask

  task automatic quietFor(int cycles, string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (divPulse) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [10:0] w;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(divPulse == 1'b0, "R8 reset state", int'(divPulse), 0);

    // R4: exhaustive validity over every word
    for (int i = 0; i < 2048; i++) begin
      @(negedge clk);
      ctrlWord = 11'(i);
      #1;
      check(cfgValid == expValid(11'(i)), "R4 validity", int'(cfgValid), int'(expValid(11'(i))));
    end

    // R2: field split, M=2 A=1 gives 17 and M=5 A=3 gives 43
    resetRun(11'h011, "R2 word 0x011 spacing");
    resetRun({8'd5, 3'd3}, "R2 M=5 A=3 spacing");

    // R1 / R3: every valid pair with M up to 8
    for (int m = 1; m <= 8; m++) begin
      for (int a = 0; a <= m && a <= 7; a++) begin
        w = {8'(m), 3'(a)};
        if (a == 0) resetRun(w, "R3 A=0 gives 8M");
        else        resetRun(w, "R1 modulus 8M+A");
      end
    end

    // R7: change mid-division, old modulus must finish first
    resetRun({8'd9, 3'd2}, "R1 modulus 74");
    repeat (3) @(negedge clk);
    ctrlWord = {8'd20, 3'd7};
    waitPulse(n);
    check(n + 3 == 74, "R7 running division keeps old modulus", n + 3, 74);
    waitPulse(n);
    check(n == 167, "R7 new modulus after boundary", n, 167);

    // R5: invalid word while running (mid-division)
    repeat (5) @(negedge clk);
    ctrlWord = {8'd3, 3'd5};
    #1;
    check(cfgValid == 1'b0, "R5 A>M flagged invalid", int'(cfgValid), 0);
    quietFor(200, "R5 no pulses while invalid");
    ctrlWord = {8'd0, 3'd0};
    quietFor(50, "R5 no pulses with M=0");

    // R9: recovery from invalid word
    ctrlWord = {8'd10, 3'd4};
    waitPulse(n);
    check(n == 84, "R9 first pulse after word turns valid", n, 84);
    waitPulse(n);
    check(n == 84, "R1 spacing after recovery", n, 84);

    // R10: boundary and random moduli from 56 to 2047
    resetRun({8'd7, 3'd0}, "R10 modulus 56");
    resetRun({8'd255, 3'd7}, "R10 modulus 2047");
    for (int k = 0; k < 12; k++) begin
      int md;
      md = 56 + int'($urandom_range(0, 2047 - 56));
      w = {8'(md / 8), 3'(md % 8)};
      check(cfgValid == 1'b1 || expValid(w), "R10 realisable", int'(expValid(w)), 1);
      resetRun(w, "R10 random modulus spacing");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule